// File: doc/BRIEF.md
# Dual-Channel Bridge Interrupt Register Block

This block is the register front end of a two-channel peripheral bridge. Channel 0 serves the disk-drive (IDE) side and channel 1 serves the expansion-bus (ISA) side. Each channel has four 16-bit registers: control, priority level, interrupt enable and event status. One read-only word reports which channels the board fitted, from strap pins.

Each channel has 16 event inputs. A rising edge on an input sets the matching status bit, which stays set until software writes a one to that bit. The enabled status bits are ORed into one interrupt request per channel. Each channel also drives a 4-bit priority code that software programs.

Bit 15 of a channel's control word releases that channel from reset. The usual start-up sequence writes 0 to the control word and then 0x8000. While the bit is low, the channel's request is held low and new events are dropped. The register port is a plain synchronous strobe bus with a read data register.

Top module: `brg_irq_regs`

## Requirements
- R1: After the asynchronous active-low reset, every control, level, enable and status register reads 0, both requests are low, both level outputs are 0 and the read data is 0.
- R2: Byte offset 0x02 returns the strap inputs in bits 1:0 (bit 0 = channel 0 fitted, bit 1 = channel 1 fitted) and zeros above them. Writes to this offset change nothing.
- R3: Channel 0 occupies 0x18 (control), 0x1A (level), 0x1C (enable) and 0x1E (status). Channel 1 occupies 0x28, 0x2A, 0x2C and 0x2E in the same order. Control and enable read back all 16 written bits. Level keeps only bits 3:0 and reads them back with zeros above.
- R4: A 0-to-1 transition on a channel's event input bit sets the status bit of the same index. The bit stays set after the input falls. An input held high sets the bit only once, so after a clear it stays 0 while the input remains high.
- R5: A write to a status offset clears exactly the status bits that are 1 in the write data. Writing 0xFFFF clears all of them, and writing 0 changes nothing.
- R6: While control bit 15 is 1, the channel request is high exactly when some status bit is 1 and its enable bit is 1. An enable bit of 0 blocks its status bit.
- R7: While control bit 15 is 0, the channel request is low and event edges do not set status bits. Writing 0x8000 to control releases the channel.
- R8: Each channel's level output equals bits 3:0 of its level register, whatever the state of the run bit.
- R9: If an event edge and a status write with a 1 in the same bit arrive in the same cycle, the bit ends up set.
- R10: Reads of offsets not listed in R2 and R3, including odd offsets, return 0. Writes to such offsets change no register.
- R11: Read data appears in the cycle after the cycle in which the read strobe is high. Read data is 0 after any cycle without a read strobe. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fit | input | NCH (2) | Channel-fitted straps, reported at offset 0x02 |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_wdata | input | DW (16) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (16) | Registered read data |
| chan_evt | input | NCH x DW | Event inputs, one 16-bit word per channel |
| chan_irq | output | NCH (2) | Interrupt request per channel |
| chan_lvl | output | NCH x LW | Priority code per channel |

## Verification
The bench builds the block with its default parameters: 16-bit words, 4-bit level codes, two channels at 0x18 and 0x28, and the strap word at 0x02. Both straps are tied high. Under this build every offset that software uses is reachable, as are the channel-0 bit 0 path and the channel-1 bit 10 path. It also reaches the odd and out-of-window offsets that lie between the two channel windows. A behavioural model runs beside the block and is compared with the requests, level outputs and read data on every cycle. It covers directed sequences for reset release, sticky status, write-one-to-clear races and masking, followed by several thousand cycles of random bus traffic and random events.

// File: rtl/brg_irq_pkg.sv
package brg_irq_pkg;

    // Register select inside one channel window; bits [2:1] of the offset
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LVL  = 2'd1,
        SEL_ENA  = 2'd2,
        SEL_STAT = 2'd3
    } chan_sel_t;

endpackage

// File: rtl/brg_irq_decode.sv
module brg_irq_decode
    import brg_irq_pkg::*;
#(
    parameter int                      AW       = 8,
    parameter int                      NCH      = 2,
    parameter logic [AW-1:0]           FEAT_OFS = 8'h02,
    parameter logic [NCH-1:0][AW-1:0]  CH_BASE  = {8'h28, 8'h18}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    output logic            feat_hit,
    output logic [NCH-1:0]  ch_hit,
    output chan_sel_t       sel
);

    localparam int WIN_LSB = 3;

    assign feat_hit = (addr == FEAT_OFS);
    assign sel      = chan_sel_t'(addr[2:1]);

    for (genvar c = 0; c < NCH; c++) begin : g_hit
        assign ch_hit[c] = (addr[AW-1:WIN_LSB] == CH_BASE[c][AW-1:WIN_LSB]) && !addr[0];
    end

    // At most one target answers any offset
    assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_hit, feat_hit}));

endmodule

// File: rtl/brg_irq_chan.sv
module brg_irq_chan
    import brg_irq_pkg::*;
#(
    parameter int DW      = 16,
    parameter int LW      = 4,
    parameter int RUN_BIT = DW - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  chan_sel_t       sel,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   evt,
    output logic [DW-1:0]   rd_val,
    output logic            irq,
    output logic [LW-1:0]   lvl
);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [LW-1:0] lvl;
        logic [DW-1:0] ena;
        logic [DW-1:0] stat;
        logic [DW-1:0] evt_prev;
    } chan_st_t;

    chan_st_t      st_q, st_d;
    logic          run;
    logic [DW-1:0] rise_g;
    logic [DW-1:0] clr;

    always_comb begin
        st_d   = st_q;
        run    = st_q.ctrl[RUN_BIT];
        rise_g = run ? (evt & ~st_q.evt_prev) : '0;
        clr    = (wr_en && sel == SEL_STAT) ? wdata : '0;
        st_d.evt_prev = evt;
        if (wr_en) begin
            case (sel)
                SEL_CTRL: st_d.ctrl = wdata;
                SEL_LVL:  st_d.lvl  = wdata[LW-1:0];
                SEL_ENA:  st_d.ena  = wdata;
                default:  ;
            endcase
        end
        // new edge dominates a same-cycle clear
        st_d.stat = (st_q.stat & ~clr) | rise_g;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rd_val = st_q.ctrl;
            SEL_LVL:  rd_val = {{(DW-LW){1'b0}}, st_q.lvl};
            SEL_ENA:  rd_val = st_q.ena;
            default:  rd_val = st_q.stat;
        endcase
    end

    assign irq = run && |(st_q.stat & st_q.ena);
    assign lvl = st_q.lvl;

    // Status bits fall only through a status write
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_STAT) |=> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat)));

    // Written ones clear unless an edge arrived with them
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STAT) |=> ((st_q.stat & $past(wdata) & ~$past(rise_g)) == '0));

    // Edge wins over a simultaneous clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_g != '0) |=> ((st_q.stat & $past(rise_g)) == $past(rise_g)));

    // Channel in reset: no new status bits
    assert_no_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((st_q.stat & ~$past(st_q.stat)) == '0));

    // Level output follows the last write to the level register
    assert_lvl_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LVL) |=> (lvl == $past(wdata[LW-1:0])));

endmodule

// File: rtl/brg_irq_regs.sv
module brg_irq_regs
    import brg_irq_pkg::*;
#(
    parameter int                      DW       = 16,
    parameter int                      AW       = 8,
    parameter int                      LW       = 4,
    parameter int                      NCH      = 2,
    parameter logic [AW-1:0]           FEAT_OFS = 8'h02,
    parameter logic [NCH-1:0][AW-1:0]  CH_BASE  = {8'h28, 8'h18}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           strap_fit,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [DW-1:0]            bus_rdata,
    input  logic [NCH-1:0][DW-1:0]   chan_evt,
    output logic [NCH-1:0]           chan_irq,
    output logic [NCH-1:0][LW-1:0]   chan_lvl
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_st_t;

    logic                    feat_hit;
    logic [NCH-1:0]          ch_hit;
    chan_sel_t               sel;
    logic [NCH-1:0][DW-1:0]  ch_rd;
    top_st_t                 top_q, top_d;

    brg_irq_decode #(
        .AW(AW), .NCH(NCH), .FEAT_OFS(FEAT_OFS), .CH_BASE(CH_BASE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr),
        .feat_hit(feat_hit), .ch_hit(ch_hit), .sel(sel)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        brg_irq_chan #(.DW(DW), .LW(LW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && ch_hit[c]),
            .sel   (sel),
            .wdata (bus_wdata),
            .evt   (chan_evt[c]),
            .rd_val(ch_rd[c]),
            .irq   (chan_irq[c]),
            .lvl   (chan_lvl[c])
        );
    end

    always_comb begin
        top_d.rdata = '0;
        if (bus_rd) begin
            if (feat_hit) top_d.rdata = {{(DW-NCH){1'b0}}, strap_fit};
            for (int c = 0; c < NCH; c++)
                if (ch_hit[c]) top_d.rdata = ch_rd[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_rdata = top_q.rdata;

    // Idle bus cycle leaves zero on the read data
    assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // Strap word is reported as read
    assert_strap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == FEAT_OFS) |=> (bus_rdata == {{(DW-NCH){1'b0}}, $past(strap_fit)}));

endmodule

// File: tb/sim_brg_irq_regs.sv
`timescale 1ns/1ps
module sim_brg_irq_regs;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        strap = 2'b11;
    logic [7:0]        addr = '0;
    logic [15:0]       wdata = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [15:0]       rdata;
    logic [1:0][15:0]  evt = '0;
    logic [1:0]        irq;
    logic [1:0][3:0]   lvl;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural model state
    bit [15:0] m_ctrl[2], m_lvl[2], m_ena[2], m_stat[2], m_prev[2];
    bit [15:0] m_rdata;

    always #10 clk = ~clk;

    brg_irq_regs u0 (
        .clk(clk), .rst_n(rst_n), .strap_fit(strap),
        .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd),
        .bus_rdata(rdata), .chan_evt(evt), .chan_irq(irq), .chan_lvl(lvl)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [15:0] model_read(input bit [7:0] a);
        case (a)
            8'h02: return {14'b0, strap};
            8'h18: return m_ctrl[0];
            8'h1A: return {12'b0, m_lvl[0][3:0]};
            8'h1C: return m_ena[0];
            8'h1E: return m_stat[0];
            8'h28: return m_ctrl[1];
            8'h2A: return {12'b0, m_lvl[1][3:0]};
            8'h2C: return m_ena[1];
            8'h2E: return m_stat[1];
            default: return 16'h0;
        endcase
    endfunction

    task automatic compare_all();
        for (int c = 0; c < 2; c++) begin
            bit exp_irq;
            exp_irq = m_ctrl[c][15] && ((m_stat[c] & m_ena[c]) != 0);
            check(irq[c] == exp_irq, "R6/R7 irq", irq[c], exp_irq);
            check(lvl[c] == m_lvl[c][3:0], "R8 lvl", lvl[c], m_lvl[c][3:0]);
        end
        check(rdata == m_rdata, "R11 rdata", rdata, m_rdata);
    endtask

    // one clock: apply inputs, advance model, compare after the edge
    task automatic cyc(input bit [7:0] a, input bit [15:0] d, input bit w, input bit r,
                       input bit [15:0] e0, input bit [15:0] e1);
        bit [15:0] n_ctrl[2], n_lvl[2], n_ena[2], n_stat[2];
        bit [15:0] n_rd;
        bit [15:0] ev[2];
        bit [7:0]  base;
        addr = a; wdata = d; wr = w; rd = r; evt[0] = e0; evt[1] = e1;
        ev[0] = e0; ev[1] = e1;
        n_rd = r ? model_read(a) : 16'h0;
        for (int c = 0; c < 2; c++) begin
            base = (c == 0) ? 8'h18 : 8'h28;
            n_ctrl[c] = m_ctrl[c]; n_lvl[c] = m_lvl[c]; n_ena[c] = m_ena[c];
            n_stat[c] = m_stat[c];
            if (w && a == base)        n_ctrl[c] = d;
            if (w && a == base + 8'd2) n_lvl[c]  = {12'b0, d[3:0]};
            if (w && a == base + 8'd4) n_ena[c]  = d;
            if (w && a == base + 8'd6) n_stat[c] = n_stat[c] & ~d;
            if (m_ctrl[c][15])         n_stat[c] = n_stat[c] | (ev[c] & ~m_prev[c]);
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            m_ctrl[c] = n_ctrl[c]; m_lvl[c] = n_lvl[c]; m_ena[c] = n_ena[c];
            m_stat[c] = n_stat[c]; m_prev[c] = ev[c];
        end
        m_rdata = n_rd;
        compare_all();
    endtask

    task automatic wr_reg(input bit [7:0] a, input bit [15:0] d);
        cyc(a, d, 1'b1, 1'b0, 16'h0, 16'h0);
    endtask

    task automatic rd_chk(input bit [7:0] a, input bit [15:0] exp, input string req);
        cyc(a, 16'h0, 1'b0, 1'b1, 16'h0, 16'h0);
        check(rdata == exp, req, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(8'h00, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit [7:0] pick[12];
        pick = '{8'h02, 8'h18, 8'h1A, 8'h1C, 8'h1E, 8'h28, 8'h2A, 8'h2C, 8'h2E,
                 8'h19, 8'h20, 8'h2E};

        // R1: reset state
        repeat (3) @(negedge clk);
        check(irq == 2'b00, "R1 irq", irq, 0);
        check(lvl == '0, "R1 lvl", lvl, 0);
        check(rdata == 16'h0, "R1 rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(8'h1E, 16'h0, "R1 stat0");
        rd_chk(8'h2C, 16'h0, "R1 ena1");

        // R2: feature straps, writes ignored
        rd_chk(8'h02, 16'h0003, "R2 feature");
        wr_reg(8'h02, 16'hFFFC);
        rd_chk(8'h02, 16'h0003, "R2 feature after write");

        // R3: offsets and widths
        wr_reg(8'h18, 16'h1234);
        rd_chk(8'h18, 16'h1234, "R3 ctrl0");
        wr_reg(8'h1A, 16'hFFF1);
        rd_chk(8'h1A, 16'h0001, "R3 lvl0");
        check(lvl[0] == 4'h1, "R8 lvl0 out", lvl[0], 1);
        wr_reg(8'h1C, 16'h0001);
        rd_chk(8'h1C, 16'h0001, "R3 ena0");

        // R7: held in reset, edge dropped
        cyc(8'h00, 16'h0, 1'b0, 1'b0, 16'h0001, 16'h0);
        idle(1);
        rd_chk(8'h1E, 16'h0000, "R7 no capture");
        check(irq[0] == 1'b0, "R7 irq low", irq[0], 0);

        // release, R4 sticky, R6 request
        wr_reg(8'h18, 16'h0000);
        wr_reg(8'h18, 16'h8000);
        cyc(8'h00, 16'h0, 1'b0, 1'b0, 16'h0001, 16'h0);
        idle(2);
        check(irq[0] == 1'b1, "R6 irq0 set", irq[0], 1);
        rd_chk(8'h1E, 16'h0001, "R4 sticky stat0");
        wr_reg(8'h1C, 16'h0000);
        check(irq[0] == 1'b0, "R6 masked", irq[0], 0);
        wr_reg(8'h1C, 16'h0001);
        check(irq[0] == 1'b1, "R6 unmasked", irq[0], 1);

        // R5: write-one-to-clear
        wr_reg(8'h1E, 16'h0000);
        rd_chk(8'h1E, 16'h0001, "R5 zero write keeps");
        wr_reg(8'h1E, 16'h0001);
        check(irq[0] == 1'b0, "R5 cleared irq", irq[0], 0);
        rd_chk(8'h1E, 16'h0000, "R5 cleared stat");

        // R4: level held high sets once
        for (int i = 0; i < 3; i++) cyc(8'h00, 16'h0, 1'b0, 1'b0, 16'h0020, 16'h0);
        cyc(8'h1E, 16'hFFFF, 1'b1, 1'b0, 16'h0020, 16'h0);
        cyc(8'h1E, 16'h0, 1'b0, 1'b1, 16'h0020, 16'h0);
        check(rdata == 16'h0000, "R4 held input no reset", rdata, 0);

        // R9: edge and clear in the same cycle
        cyc(8'h00, 16'h0, 1'b0, 1'b0, 16'h0000, 16'h0);
        cyc(8'h1E, 16'h0008, 1'b1, 1'b0, 16'h0008, 16'h0);
        rd_chk(8'h1E, 16'h0008, "R9 set wins");
        wr_reg(8'h1E, 16'hFFFF);
        rd_chk(8'h1E, 16'h0000, "R5 clear all");

        // channel 1, source bit 10
        wr_reg(8'h28, 16'h0000);
        wr_reg(8'h28, 16'h8000);
        wr_reg(8'h2A, 16'h0005);
        wr_reg(8'h2C, 16'hFFF8);
        check(lvl[1] == 4'h5, "R8 lvl1 out", lvl[1], 5);
        cyc(8'h00, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0400);
        idle(1);
        check(irq[1] == 1'b1, "R6 irq1 bit10", irq[1], 1);
        check(irq[0] == 1'b0, "R6 irq0 independent", irq[0], 0);
        rd_chk(8'h2E, 16'h0400, "R3 stat1");
        cyc(8'h00, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0002);
        wr_reg(8'h2E, 16'h0400);
        check(irq[1] == 1'b0, "R6 masked bit1", irq[1], 0);
        rd_chk(8'h2E, 16'h0002, "R6 stat1 bit1");

        // R10: unmapped offsets
        wr_reg(8'h40, 16'hFFFF);
        wr_reg(8'h19, 16'h0000);
        rd_chk(8'h40, 16'h0000, "R10 read 0x40");
        rd_chk(8'h19, 16'h0000, "R10 read odd");
        rd_chk(8'h18, 16'h8000, "R10 ctrl0 untouched");

        // R11: read data timing
        cyc(8'h2A, 16'h0, 1'b0, 1'b1, 16'h0, 16'h0);
        check(rdata == 16'h0005, "R11 data next cycle", rdata, 5);
        idle(1);
        check(rdata == 16'h0000, "R11 zero when idle", rdata, 0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit [7:0]  a;
            bit [15:0] d, e0, e1;
            int        k;
            k  = $urandom_range(0, 11);
            a  = (i % 97 == 0) ? 8'($urandom) : pick[k];
            d  = 16'($urandom);
            if (a == 8'h18 || a == 8'h28) d[15] = ($urandom_range(0, 3) != 0);
            e0 = 16'($urandom) & 16'($urandom) & 16'($urandom);
            e1 = 16'($urandom) & 16'($urandom) & 16'($urandom);
            cyc(a, d, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0, e0, e1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule